// File: doc/BRIEF.md
# Registered Split-Port Synchronous SRAM

This block is a single-clock static memory with one write-data bus going in and one read-data bus coming out. Every rising edge registers the address, the write data, the write strobe, two chip selects of opposite polarity and a bypass control. In the following cycle the block works on that one registered address. It can read the word, write the word, or read the old word and write the new one in the same cycle. The result goes into an output register on the next edge.

When the bypass control is registered high, the output register takes the registered write data instead of the array word. A write that comes with it still reaches the array. An asynchronous output enable decides whether the read bus is driven. On chip it is shown as a pad-driver enable together with a data bus that is held at zero while the enable is off. Reset clears the pipeline registers only, never the stored words. The array depth and word width are parameters. The default keeps elaboration small, and `ADDR_W = 16` with `DATA_W = 18` gives the full 64K x 18 organisation.

Top module: `spio_sram`

## Requirements
- R1: Controls and data registered at rising edge n produce their result in the output register at edge n+1, and not before.
- R2: The block is selected only when `sel_n_i` is registered low and `sel_i` is registered high. When it is not selected, no word is written and the output register keeps its value.
- R3: A selected cycle with `wr_n_i` registered low stores the registered `din_i` at the registered address. A later read of that address returns it.
- R4: A selected cycle that both reads and writes one address loads the previous contents of the word into the output register, not the new data.
- R5: A read of an address written in the immediately preceding cycle returns the newly written data, with no idle cycle in between.
- R6: With `thru_i` registered high in a selected cycle, the output register loads the registered `din_i` instead of the array word. An accompanying write still updates the array.
- R7: `q_oe_o` follows the inverse of `oe_n_i` without a clock. While it is low, `q_o` reads zero. The output register is unaffected, and its value reappears as soon as `oe_n_i` returns low.
- R8: A synchronous high `rst` clears the output register to zero and deselects the registered controls. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Word address |
| din_i | input | DATA_W | Write data bus |
| wr_n_i | input | 1 | Write strobe, active low |
| sel_n_i | input | 1 | Chip select, active low |
| sel_i | input | 1 | Chip select, active high |
| thru_i | input | 1 | Bypass: output takes write data |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| q_o | output | DATA_W | Read data bus, zero while not enabled |
| q_oe_o | output | 1 | Pad driver enable for the read bus |

## Verification
The bench builds the block with `ADDR_W = 6` and `DATA_W = 18`. Sixty-four words are few enough to fill completely at start. Random addresses then hit the same word back to back often, so combined read/write, write-then-read and bypass cycles on recently written words come up many times alongside the directed cases. The full data width keeps bypass data and array data easy to tell apart.

// File: rtl/spio_pkg.sv
package spio_pkg;

    // Source feeding the output register in a given cycle
    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_ARRAY = 2'd1,
        SRC_INPUT = 2'd2
    } out_src_e;

    function automatic logic chip_selected(input logic sel_n, input logic sel);
        return (!sel_n) && sel;
    endfunction

    function automatic out_src_e pick_source(input logic active, input logic thru);
        if (!active) return SRC_HOLD;
        if (thru)    return SRC_INPUT;
        return SRC_ARRAY;
    endfunction

endpackage

// File: rtl/spio_capture.sv
module spio_capture #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              wr_n_i,
    input  logic              sel_n_i,
    input  logic              sel_i,
    input  logic              thru_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] din_o,
    output logic              active_o,
    output logic              write_o,
    output logic              thru_o
);
    import spio_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
        logic              wr_n;
        logic              sel_n;
        logic              sel;
        logic              thru;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (rst) begin
            cap_d.addr  = '0;
            cap_d.din   = '0;
            cap_d.wr_n  = 1'b1;
            cap_d.sel_n = 1'b1;
            cap_d.sel   = 1'b0;
            cap_d.thru  = 1'b0;
        end else begin
            cap_d.addr  = addr_i;
            cap_d.din   = din_i;
            cap_d.wr_n  = wr_n_i;
            cap_d.sel_n = sel_n_i;
            cap_d.sel   = sel_i;
            cap_d.thru  = thru_i;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign addr_o   = cap_q.addr;
    assign din_o    = cap_q.din;
    assign active_o = chip_selected(cap_q.sel_n, cap_q.sel);
    assign write_o  = active_o && !cap_q.wr_n;
    assign thru_o   = cap_q.thru;

    // R8: the cycle after reset carries no selected operation
    assert_reset_idle_R8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !active_o);

endmodule

// File: rtl/spio_array.sv
module spio_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Read happens during the cycle, the write lands at its closing edge,
    // so a combined cycle sees the old word.
    assign rdata_o = mem_q[addr_i];

    always_ff @(posedge clk) begin
        if (wr_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    // R5: a word written at one edge is visible to a read in the next cycle
    assert_fresh_read_R5: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> ((addr_i != $past(addr_i)) || (rdata_o == $past(wdata_i))));

endmodule

// File: rtl/spio_outreg.sv
module spio_outreg #(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active_i,
    input  logic              thru_i,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] q_o,
    output logic              q_oe_o
);
    import spio_pkg::*;

    out_src_e          src;
    logic [DATA_W-1:0] q_d, q_q;

    always_comb begin
        src = pick_source(active_i, thru_i);
        q_d = q_q;
        if (rst) begin
            q_d = '0;
        end else begin
            case (src)
                SRC_ARRAY: q_d = rdata_i;
                SRC_INPUT: q_d = din_i;
                default:   q_d = q_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        q_q <= q_d;
    end

    assign q_oe_o = !oe_n_i;
    assign q_o    = q_oe_o ? q_q : '0;

    // R2: a deselected cycle leaves the output register alone
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !active_i |=> $stable(q_q));

    // R6: bypass loads the registered write data
    assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
        (active_i && thru_i) |=> (q_q == $past(din_i)));

    // R4: a selected non-bypass cycle returns the word read before any write
    assert_old_word_R4: assert property (@(posedge clk) disable iff (rst)
        (active_i && !thru_i) |=> (q_q == $past(rdata_i)));

endmodule

// File: rtl/spio_sram.sv
module spio_sram #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic              wr_n_i,
    input  logic              sel_n_i,
    input  logic              sel_i,
    input  logic              thru_i,
    input  logic              oe_n_i,
    output logic [DATA_W-1:0] q_o,
    output logic              q_oe_o
);
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_din;
    logic              cap_active;
    logic              cap_write;
    logic              cap_thru;
    logic [DATA_W-1:0] arr_rdata;
    logic              arr_wr;

    spio_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .addr_i   (addr_i),
        .din_i    (din_i),
        .wr_n_i   (wr_n_i),
        .sel_n_i  (sel_n_i),
        .sel_i    (sel_i),
        .thru_i   (thru_i),
        .addr_o   (cap_addr),
        .din_o    (cap_din),
        .active_o (cap_active),
        .write_o  (cap_write),
        .thru_o   (cap_thru)
    );

    // A reset edge discards the pending operation, write included
    assign arr_wr = cap_write && !rst;

    spio_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (cap_addr),
        .wr_i    (arr_wr),
        .wdata_i (cap_din),
        .rdata_o (arr_rdata)
    );

    spio_outreg #(.DATA_W(DATA_W)) u_outreg (
        .clk      (clk),
        .rst      (rst),
        .active_i (cap_active),
        .thru_i   (cap_thru),
        .rdata_i  (arr_rdata),
        .din_i    (cap_din),
        .oe_n_i   (oe_n_i),
        .q_o      (q_o),
        .q_oe_o   (q_oe_o)
    );

endmodule

// File: tb/spio_sram_tb.sv
module spio_sram_tb;
    localparam int AW = 6;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          wr_n = 1'b1, sel_n = 1'b1, sel = 1'b0, thru = 1'b0, oe_n = 1'b0;
    logic [DW-1:0] q;
    logic          q_oe;

    always #5 clk = ~clk;

    spio_sram #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .addr_i(addr), .din_i(din), .wr_n_i(wr_n),
        .sel_n_i(sel_n), .sel_i(sel), .thru_i(thru), .oe_n_i(oe_n),
        .q_o(q), .q_oe_o(q_oe)
    );

    int total = 0;
    int bad   = 0;

    // Reference model state
    logic [DW-1:0] ref_mem [DEPTH];
    bit            ref_ok  [DEPTH];
    logic          p_act = 0, p_wr = 0, p_thru = 0;
    logic [AW-1:0] p_addr = '0;
    logic [DW-1:0] p_din = '0;
    logic [DW-1:0] exp_q = '0;
    bit            exp_known = 0;
    string         exp_tag = "R8";
    bit            last_wr = 0;
    logic [AW-1:0] last_wr_addr = '0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] seed_word(input int i);
        return DW'((i * 32'h9E37) ^ 32'h2A5A5);
    endfunction

    // Applies the pending operation at an edge, then latches the new one
    task automatic model(input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic w_n, input logic s_n, input logic s, input logic t);
        if (r) begin
            exp_q = '0; exp_known = 1; exp_tag = "R8";
            p_act = 0; p_wr = 0; last_wr = 0;
            return;
        end
        if (p_act) begin
            if (p_thru) begin
                exp_q = p_din; exp_known = 1; exp_tag = "R6";
            end else begin
                exp_q = ref_mem[p_addr]; exp_known = ref_ok[p_addr];
                if (p_wr)                              exp_tag = "R4";
                else if (last_wr && last_wr_addr == p_addr) exp_tag = "R5";
                else                                   exp_tag = "R3";
            end
            if (p_wr) begin
                ref_mem[p_addr] = p_din; ref_ok[p_addr] = 1;
            end
            last_wr = p_wr; last_wr_addr = p_addr;
        end else begin
            exp_tag = "R2"; last_wr = 0;
        end
        p_act  = !s_n && s;
        p_wr   = p_act && !w_n;
        p_thru = t;
        p_addr = a;
        p_din  = d;
    endtask

    task automatic step(input logic r, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic w_n, input logic s_n, input logic s, input logic t);
        @(negedge clk);
        if (exp_known) check(exp_tag, q, exp_q);
        rst = r; addr = a; din = d; wr_n = w_n; sel_n = s_n; sel = s; thru = t;
        @(posedge clk);
        #1;
        model(r, a, d, w_n, s_n, s, t);
    endtask

    task automatic idle();
        step(0, '0, '0, 1, 1, 0, 0);
    endtask

    initial begin
        #(200000 * 10);
        bad++; total++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) ref_ok[i] = 0;

        // R8: reset state
        step(1, '0, '0, 1, 1, 0, 0);
        step(1, '0, '0, 1, 1, 0, 0);
        @(negedge clk);
        check("R8", q, '0);
        check("R7", {{(DW-1){1'b0}}, q_oe}, {{(DW-1){1'b0}}, 1'b1});

        // Fill the array (R3)
        for (int i = 0; i < DEPTH; i++) step(0, AW'(i), seed_word(i), 0, 0, 1, 0);
        idle();
        for (int i = 0; i < 4; i++) step(0, AW'(i), '0, 1, 0, 1, 0);
        idle();

        // R1: bypass value must not appear at the capture edge, only one edge later
        step(0, AW'(9), 18'h3C3C3, 1, 0, 1, 1);
        check("R1", q, exp_q);
        check("R1", (q == 18'h3C3C3) ? 18'h1 : 18'h0, 18'h0);
        idle();
        @(negedge clk);
        check("R1", q, 18'h3C3C3);

        // R4: combined read/write returns old word; R5: next read gets new word
        step(0, AW'(5), 18'h11111, 0, 0, 1, 0);
        step(0, AW'(5), '0, 1, 0, 1, 0);
        idle();
        @(negedge clk);
        check("R5", q, 18'h11111);

        // R6: bypass with write still updates the array
        step(0, AW'(6), 18'h22222, 0, 0, 1, 1);
        step(0, AW'(6), '0, 1, 0, 1, 0);
        idle();
        @(negedge clk);
        check("R6", q, 18'h22222);

        // R2: either select inactive blocks the write and holds the output
        step(0, AW'(7), 18'h0BAD0, 0, 1, 1, 0);
        step(0, AW'(8), 18'h0BAD1, 0, 0, 0, 1);
        idle();
        step(0, AW'(7), '0, 1, 0, 1, 0);
        step(0, AW'(8), '0, 1, 0, 1, 0);
        idle();
        @(negedge clk);
        check("R2", q, seed_word(8));

        // R7: output enable gates the bus without touching the register
        @(negedge clk);
        oe_n = 1'b1;
        #1;
        check("R7", q, '0);
        check("R7", {{(DW-1){1'b0}}, q_oe}, '0);
        oe_n = 1'b0;
        #1;
        check("R7", q, seed_word(8));
        check("R7", {{(DW-1){1'b0}}, q_oe}, {{(DW-1){1'b0}}, 1'b1});

        // R8: reset mid-run clears output, keeps array
        step(0, AW'(10), '0, 1, 0, 1, 0);
        step(1, AW'(10), 18'h3FFFF, 0, 0, 1, 0);
        idle();
        @(negedge clk);
        check("R8", q, '0);
        step(0, AW'(10), '0, 1, 0, 1, 0);
        idle();
        @(negedge clk);
        check("R8", q, seed_word(10));

        // Random mix (all requirements through the reference model)
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] ra;
            int            k;
            ra = AW'($urandom_range(0, 7) < 3 ? p_addr : AW'($urandom));
            k  = $urandom_range(0, 9);
            step(0, ra, DW'($urandom),
                 (k < 5) ? 1'b0 : 1'b1,
                 (k == 9) ? 1'b1 : 1'b0,
                 (k == 8) ? 1'b0 : 1'b1,
                 ($urandom_range(0, 5) == 0) ? 1'b1 : 1'b0);
        end
        idle();
        idle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule